// File: doc/BRIEF.md
# Machine Control and Status Register Access Unit

This unit holds the control and status registers of a 32-bit hart and carries out the six register-access instructions: swap, bit-set and bit-clear, each in a register-operand form and a 5-bit immediate form. For every accepted request it returns the value the register held before the access and a flag that tells whether the access was rejected. The pipeline presents one request at a time. The request carries the 12-bit register address, the 3-bit function code, the source operand (a register value or an immediate), flags saying whether the source and destination register fields are zero, and the privilege level the hart currently runs at.

The unit keeps a 64-bit count of retired instructions, advanced by a pulse from the pipeline, and it exposes that count under both the cycle and the instret names. It also keeps a 64-bit copy of an external time value, taken when each request is accepted. The machine information registers and the ISA description register are constants, apart from the hart ID, which is captured from an input while reset is held. Access rights come from the address alone. Address bits [9:8] give the lowest privilege that may touch the register. When both address bits [11:10] are set, the register cannot be written.

A three-state controller sequences each request. ST_IDLE waits. A request seen in ST_IDLE is latched (transition IDLE->ACCESS). ST_ACCESS decodes, checks rights, reads the register and applies any write (transition ACCESS->REPLY). ST_REPLY presents the result for one cycle (transition REPLY->IDLE).

Top module: `hart_csr_unit`

## Requirements
- R1: A request with req_valid high at a rising edge in ST_IDLE produces rsp_valid high for exactly one cycle, starting two rising edges after acceptance. req_valid is ignored while the unit is in ST_ACCESS or ST_REPLY.
- R2: Privilege encodings are user=0, supervisor=1, machine=3. If address bits [9:8] exceed cur_priv, the access is rejected: rsp_illegal=1 and rsp_rdata=0.
- R3: If address bits [11:10] are both 1 and the access intends a write, it is rejected. Function codes 1 (swap) and 5 (swap immediate) always intend a write. Codes 2, 3, 6 and 7 (set, clear, set immediate, clear immediate) intend a write only when req_rs1_zero=0. With req_rs1_zero=1 they are plain reads and succeed.
- R4: An address outside the implemented set, or a function code of 0 or 4, is rejected with rsp_illegal=1 and rsp_rdata=0, and no state changes. The implemented addresses are 0xC00, 0xC01, 0xC02, 0xC80, 0xC81, 0xC82, 0xF11, 0xF12, 0xF13, 0xF14 and 0x301.
- R5: For swap (1) and swap-immediate (5) with req_rd_zero=1, no read is done, and a legal access returns rsp_rdata=0.
- R6: A 64-bit retired-instruction counter is zero after reset and adds one for each cycle in which retire_pulse is high. 0xC00 and 0xC02 return its low 32 bits. 0xC80 and 0xC82 return its high 32 bits.
- R7: 0xC01 and 0xC81 return the low and high halves of time_in as sampled at the edge that accepted the request, not its later value.
- R8: 0xF11, 0xF12 and 0xF13 read as zero. 0xF14 reads the hart_id value captured while rst_n was low. Later changes on hart_id have no effect.
- R9: 0x301 reads 0x40141100. Legal swap, set and clear accesses to it from machine level are not rejected, return that old value, and leave it unchanged.
- R10: After reset the unit is in ST_IDLE with rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous for state; hart ID is captured while low |
| hart_id | input | 32 | Hart identifier, sampled during reset |
| req_valid | input | 1 | Request strobe, accepted in ST_IDLE |
| req_addr | input | 12 | Register address |
| req_funct | input | 3 | Function code (1,2,3 register forms; 5,6,7 immediate forms) |
| req_rs1_val | input | 32 | Source register value for the register forms |
| req_uimm | input | 5 | Immediate operand for the immediate forms, zero-extended |
| req_rs1_zero | input | 1 | Source field is zero |
| req_rd_zero | input | 1 | Destination field is zero |
| cur_priv | input | 2 | Current privilege level |
| retire_pulse | input | 1 | One instruction retired this cycle |
| time_in | input | 64 | Free-running time value |
| rsp_valid | output | 1 | Result valid (ST_REPLY) |
| rsp_rdata | output | 32 | Old register value, or zero |
| rsp_illegal | output | 1 | Access rejected |

## Verification
The hardest conditions to reach are the ones where inputs move while the unit is busy. One case is a second request held on req_valid during ST_ACCESS and ST_REPLY. The other is time_in changing between acceptance and the register read. The stimulus holds req_valid high across the busy cycles with a different address, and changes time_in on the falling edge right after acceptance. It then checks that exactly one response arrives and that it carries the first address's data and the sampled time. A vector table covers the rights matrix: every privilege level against machine-only and user-readable addresses, and write intent against read-only space, including swap with a zero destination, which still counts as a write.

// File: rtl/hart_csr_pkg.sv
package hart_csr_pkg;

    localparam int CSR_AW = 12;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_REPLY  = 2'd2
    } csr_state_e;

    typedef enum logic [2:0] {
        F3_NONE0 = 3'd0,
        F3_SWAP  = 3'd1,
        F3_SET   = 3'd2,
        F3_CLR   = 3'd3,
        F3_NONE4 = 3'd4,
        F3_SWAPI = 3'd5,
        F3_SETI  = 3'd6,
        F3_CLRI  = 3'd7
    } csr_funct_e;

    localparam logic [CSR_AW-1:0] A_CNT_LO  = 12'hC00;
    localparam logic [CSR_AW-1:0] A_TIM_LO  = 12'hC01;
    localparam logic [CSR_AW-1:0] A_RET_LO  = 12'hC02;
    localparam logic [CSR_AW-1:0] A_CNT_HI  = 12'hC80;
    localparam logic [CSR_AW-1:0] A_TIM_HI  = 12'hC81;
    localparam logic [CSR_AW-1:0] A_RET_HI  = 12'hC82;
    localparam logic [CSR_AW-1:0] A_VENDOR  = 12'hF11;
    localparam logic [CSR_AW-1:0] A_ARCH    = 12'hF12;
    localparam logic [CSR_AW-1:0] A_IMPL    = 12'hF13;
    localparam logic [CSR_AW-1:0] A_HARTID  = 12'hF14;
    localparam logic [CSR_AW-1:0] A_ISA     = 12'h301;

endpackage

// File: rtl/hart_csr_decode.sv
module hart_csr_decode
    import hart_csr_pkg::*;
(
    input  logic [CSR_AW-1:0] addr,
    input  logic [2:0]        funct,
    input  logic              rs1_zero,
    input  logic              rd_zero,
    input  logic [1:0]        priv,
    input  logic              hit,
    output logic              illegal,
    output logic              do_read,
    output logic              do_write
);
    // address fields: top pair = read-only marker, next pair = minimum privilege
    localparam int RO_HI = CSR_AW - 1;
    localparam int RO_LO = CSR_AW - 2;
    localparam int PL_HI = CSR_AW - 3;
    localparam int PL_LO = CSR_AW - 4;

    logic       op_ok;
    logic       priv_fail;
    logic       read_only;
    logic [1:0] min_priv;

    always_comb begin
        op_ok    = 1'b0;
        do_read  = 1'b0;
        do_write = 1'b0;
        unique case (csr_funct_e'(funct))
            F3_SWAP, F3_SWAPI: begin
                op_ok    = 1'b1;
                do_write = 1'b1;
                do_read  = !rd_zero;
            end
            F3_SET, F3_CLR, F3_SETI, F3_CLRI: begin
                op_ok    = 1'b1;
                do_write = !rs1_zero;
                do_read  = 1'b1;
            end
            default: begin
                op_ok    = 1'b0;
                do_write = 1'b0;
                do_read  = 1'b0;
            end
        endcase
    end

    assign min_priv  = addr[PL_HI:PL_LO];
    assign priv_fail = (min_priv > priv);
    assign read_only = &addr[RO_HI:RO_LO];
    assign illegal   = !op_ok || !hit || priv_fail || (read_only && do_write);

endmodule

// File: rtl/hart_csr_retire_ctr.sv
module hart_csr_retire_ctr #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/hart_csr_read_mux.sv
module hart_csr_read_mux
    import hart_csr_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int CNT_W = 2 * XLEN
) (
    input  logic [CSR_AW-1:0] addr,
    input  logic [CNT_W-1:0]  ret_cnt,
    input  logic [CNT_W-1:0]  time_snap,
    input  logic [XLEN-1:0]   hartid,
    input  logic [XLEN-1:0]   isa,
    output logic [XLEN-1:0]   value,
    output logic              hit
);
    logic [XLEN-1:0] cnt_half [2];
    logic [XLEN-1:0] tim_half [2];

    // split both 64-bit sources into their halves
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign cnt_half[h] = ret_cnt[h*XLEN +: XLEN];
        assign tim_half[h] = time_snap[h*XLEN +: XLEN];
    end

    always_comb begin
        hit   = 1'b1;
        value = '0;
        unique case (addr)
            A_CNT_LO, A_RET_LO: value = cnt_half[0];
            A_CNT_HI, A_RET_HI: value = cnt_half[1];
            A_TIM_LO:           value = tim_half[0];
            A_TIM_HI:           value = tim_half[1];
            A_VENDOR, A_ARCH,
            A_IMPL:             value = '0;
            A_HARTID:           value = hartid;
            A_ISA:              value = isa;
            default: begin
                hit   = 1'b0;
                value = '0;
            end
        endcase
    end
endmodule

// File: rtl/hart_csr_unit.sv
module hart_csr_unit
    import hart_csr_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] ISA_VALUE = 32'h4014_1100,
    parameter logic [XLEN-1:0] ISA_WMASK = '0,
    localparam int             CNT_W     = 2 * XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   hart_id,
    input  logic              req_valid,
    input  logic [CSR_AW-1:0] req_addr,
    input  logic [2:0]        req_funct,
    input  logic [XLEN-1:0]   req_rs1_val,
    input  logic [4:0]        req_uimm,
    input  logic              req_rs1_zero,
    input  logic              req_rd_zero,
    input  logic [1:0]        cur_priv,
    input  logic              retire_pulse,
    input  logic [CNT_W-1:0]  time_in,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              rsp_illegal
);
    csr_state_e        state, state_nx;

    logic [CSR_AW-1:0] lat_addr;
    logic [2:0]        lat_funct;
    logic [XLEN-1:0]   lat_rs1;
    logic [4:0]        lat_uimm;
    logic              lat_rs1z;
    logic              lat_rdz;
    logic [1:0]        lat_priv;
    logic [CNT_W-1:0]  time_q;
    logic [XLEN-1:0]   hartid_q;
    logic [XLEN-1:0]   isa_q;
    logic [CNT_W-1:0]  ret_cnt;

    logic [XLEN-1:0]   old_val;
    logic              reg_hit;
    logic              illegal;
    logic              do_read;
    logic              do_write;
    logic [XLEN-1:0]   operand;
    logic [XLEN-1:0]   new_val;
    logic              accept;

    logic [XLEN-1:0]   rdata_q;
    logic              ill_q;

    assign accept = (state == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = req_valid ? ST_ACCESS : ST_IDLE;
            ST_ACCESS: state_nx = ST_REPLY;
            ST_REPLY:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture, including the time sample taken at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_funct <= '0;
            lat_rs1   <= '0;
            lat_uimm  <= '0;
            lat_rs1z  <= 1'b1;
            lat_rdz   <= 1'b1;
            lat_priv  <= '0;
            time_q    <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_funct <= req_funct;
            lat_rs1   <= req_rs1_val;
            lat_uimm  <= req_uimm;
            lat_rs1z  <= req_rs1_zero;
            lat_rdz   <= req_rd_zero;
            lat_priv  <= cur_priv;
            time_q    <= time_in;
        end
    end

    // hart identifier is loaded only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) hartid_q <= hart_id;
    end

    hart_csr_retire_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (retire_pulse),
        .count (ret_cnt)
    );

    hart_csr_read_mux #(.XLEN(XLEN)) u_mux (
        .addr      (lat_addr),
        .ret_cnt   (ret_cnt),
        .time_snap (time_q),
        .hartid    (hartid_q),
        .isa       (isa_q),
        .value     (old_val),
        .hit       (reg_hit)
    );

    hart_csr_decode u_dec (
        .addr     (lat_addr),
        .funct    (lat_funct),
        .rs1_zero (lat_rs1z),
        .rd_zero  (lat_rdz),
        .priv     (lat_priv),
        .hit      (reg_hit),
        .illegal  (illegal),
        .do_read  (do_read),
        .do_write (do_write)
    );

    // write value: swap, set (OR) or clear (AND-NOT); bit 2 picks the immediate
    assign operand = lat_funct[2] ? {{(XLEN-5){1'b0}}, lat_uimm} : lat_rs1;

    always_comb begin
        unique case (lat_funct[1:0])
            2'b01:   new_val = operand;
            2'b10:   new_val = old_val | operand;
            2'b11:   new_val = old_val & ~operand;
            default: new_val = old_val;
        endcase
    end

    // ISA register: only the bits in ISA_WMASK take written values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isa_q <= ISA_VALUE;
        end else if (state == ST_ACCESS && !illegal && do_write && lat_addr == A_ISA) begin
            isa_q <= (isa_q & ~ISA_WMASK) | (new_val & ISA_WMASK);
        end
    end

    // output register, loaded in ST_ACCESS
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            ill_q   <= 1'b0;
        end else if (state == ST_ACCESS) begin
            ill_q   <= illegal;
            rdata_q <= (!illegal && do_read) ? old_val : '0;
        end
    end

    assign rsp_valid   = (state == ST_REPLY);
    assign rsp_rdata   = rdata_q;
    assign rsp_illegal = ill_q;

endmodule

// File: rtl/hart_csr_checker.sv
module hart_csr_checker
    import hart_csr_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int CNT_W = 2 * XLEN
) (
    input logic              clk,
    input logic              rst_n,
    input csr_state_e        state,
    input logic [CSR_AW-1:0] lat_addr,
    input logic [2:0]        lat_funct,
    input logic              lat_rs1z,
    input logic [1:0]        lat_priv,
    input logic              retire_pulse,
    input logic [CNT_W-1:0]  ret_cnt,
    input logic [XLEN-1:0]   hartid_q,
    input logic              rsp_valid,
    input logic              rsp_illegal,
    input logic [XLEN-1:0]   rsp_rdata
);
    p_reply_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_access_to_reply_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS) |=> rsp_valid);

    p_priv_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && lat_addr[9:8] > lat_priv) |=> (rsp_illegal && rsp_rdata == '0));

    p_ro_write_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && lat_addr[11:10] == 2'b11 &&
         (lat_funct == 3'd1 || lat_funct == 3'd5 || (lat_funct[1] && !lat_rs1z)))
        |=> rsp_illegal);

    p_illegal_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (rsp_rdata == '0));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_pulse |=> (ret_cnt == $past(ret_cnt) + 1'b1));

    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_pulse |=> $stable(ret_cnt));

    p_hartid_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(hartid_q));

endmodule

bind hart_csr_unit hart_csr_checker #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .lat_addr     (lat_addr),
    .lat_funct    (lat_funct),
    .lat_rs1z     (lat_rs1z),
    .lat_priv     (lat_priv),
    .retire_pulse (retire_pulse),
    .ret_cnt      (ret_cnt),
    .hartid_q     (hartid_q),
    .rsp_valid    (rsp_valid),
    .rsp_illegal  (rsp_illegal),
    .rsp_rdata    (rsp_rdata)
);

// File: tb/hart_csr_unit_tb.sv
`timescale 1ns/1ps
module hart_csr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hart_id = 32'h0000_00A5;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_funct = '0;
    logic [31:0] req_rs1_val = 32'hFFFF_FFFF;
    logic [4:0]  req_uimm = 5'h1F;
    logic        req_rs1_zero = 1'b1;
    logic        req_rd_zero = 1'b0;
    logic [1:0]  cur_priv = 2'd3;
    logic        retire_pulse = 1'b0;
    logic [63:0] time_in = 64'h0123_4567_89AB_CDEF;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_illegal;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic        got_valid;
    logic [31:0] got_data;
    logic        got_ill;
    logic        got_after;

    always #10 clk = ~clk;

    hart_csr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .hart_id(hart_id),
        .req_valid(req_valid), .req_addr(req_addr), .req_funct(req_funct),
        .req_rs1_val(req_rs1_val), .req_uimm(req_uimm),
        .req_rs1_zero(req_rs1_zero), .req_rd_zero(req_rd_zero),
        .cur_priv(cur_priv), .retire_pulse(retire_pulse), .time_in(time_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [2:0]  funct;
        logic        rs1z;
        logic        rdz;
        logic [1:0]  priv;
        logic        ill;
        logic [31:0] data;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 27;
    // counter holds 5, time_in holds 0x0123456789ABCDEF, hart_id captured 0xA5
    localparam vec_t VECS [NV] = '{
        '{12'h301, 3'd2, 1'b1, 1'b0, 2'd3, 1'b0, 32'h4014_1100, 8'd9},  // R9 read
        '{12'h301, 3'd2, 1'b1, 1'b0, 2'd1, 1'b1, 32'h0,         8'd2},  // R2 S
        '{12'h301, 3'd2, 1'b1, 1'b0, 2'd0, 1'b1, 32'h0,         8'd2},  // R2 U
        '{12'hF11, 3'd2, 1'b1, 1'b0, 2'd1, 1'b1, 32'h0,         8'd2},  // R2 S on M reg
        '{12'hF11, 3'd2, 1'b1, 1'b0, 2'd3, 1'b0, 32'h0,         8'd8},  // R8
        '{12'hF12, 3'd6, 1'b1, 1'b0, 2'd3, 1'b0, 32'h0,         8'd8},  // R8
        '{12'hF13, 3'd7, 1'b1, 1'b0, 2'd3, 1'b0, 32'h0,         8'd8},  // R8
        '{12'hF14, 3'd2, 1'b1, 1'b0, 2'd3, 1'b0, 32'h0000_00A5, 8'd8},  // R8
        '{12'hF14, 3'd1, 1'b0, 1'b0, 2'd3, 1'b1, 32'h0,         8'd3},  // R3 swap
        '{12'hF13, 3'd3, 1'b0, 1'b0, 2'd3, 1'b1, 32'h0,         8'd3},  // R3 clear
        '{12'hF14, 3'd7, 1'b0, 1'b0, 2'd3, 1'b1, 32'h0,         8'd3},  // R3 clear imm
        '{12'hC00, 3'd1, 1'b0, 1'b1, 2'd0, 1'b1, 32'h0,         8'd3},  // R3 swap rd=0
        '{12'hC02, 3'd6, 1'b0, 1'b0, 2'd3, 1'b1, 32'h0,         8'd3},  // R3 set imm
        '{12'hC00, 3'd2, 1'b1, 1'b0, 2'd0, 1'b0, 32'd5,         8'd6},  // R6
        '{12'hC80, 3'd2, 1'b1, 1'b0, 2'd0, 1'b0, 32'd0,         8'd6},  // R6
        '{12'hC02, 3'd3, 1'b1, 1'b0, 2'd1, 1'b0, 32'd5,         8'd6},  // R6
        '{12'hC82, 3'd6, 1'b1, 1'b0, 2'd3, 1'b0, 32'd0,         8'd6},  // R6
        '{12'hC01, 3'd2, 1'b1, 1'b0, 2'd0, 1'b0, 32'h89AB_CDEF, 8'd7},  // R7
        '{12'hC81, 3'd2, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0123_4567, 8'd7},  // R7
        '{12'h340, 3'd2, 1'b1, 1'b0, 2'd3, 1'b1, 32'h0,         8'd4},  // R4
        '{12'hF15, 3'd2, 1'b1, 1'b0, 2'd3, 1'b1, 32'h0,         8'd4},  // R4
        '{12'h301, 3'd0, 1'b1, 1'b0, 2'd3, 1'b1, 32'h0,         8'd4},  // R4 funct 0
        '{12'h301, 3'd4, 1'b1, 1'b0, 2'd3, 1'b1, 32'h0,         8'd4},  // R4 funct 4
        '{12'h301, 3'd1, 1'b0, 1'b1, 2'd3, 1'b0, 32'h0,         8'd5},  // R5 swap
        '{12'h301, 3'd5, 1'b0, 1'b1, 2'd3, 1'b0, 32'h0,         8'd5},  // R5 swap imm
        '{12'h301, 3'd1, 1'b0, 1'b0, 2'd3, 1'b0, 32'h4014_1100, 8'd9},  // R9 swap
        '{12'h301, 3'd7, 1'b0, 1'b0, 2'd3, 1'b0, 32'h4014_1100, 8'd9}   // R9 clear imm
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request: accepted at the next edge, response sampled after the second edge
    task automatic access(input logic [11:0] a, input logic [2:0] f, input logic rz,
                          input logic dz, input logic [1:0] p);
        @(negedge clk);
        req_valid    = 1'b1;
        req_addr     = a;
        req_funct    = f;
        req_rs1_zero = rz;
        req_rd_zero  = dz;
        cur_priv     = p;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        got_valid = rsp_valid;
        got_data  = rsp_rdata;
        got_ill   = rsp_illegal;
        @(posedge clk);
        @(negedge clk);
        got_after = rsp_valid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        hart_id = 32'hFFFF_0000;
        // R10: idle and quiet after reset
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

        // R6: counter starts at zero
        access(12'hC00, 3'd2, 1'b1, 1'b0, 2'd3);
        check(got_valid && !got_ill && got_data == 32'd0, "R6 count after reset",
              got_data, 32'd0);
        // R1: single-cycle response
        check(got_after == 1'b0, "R1 response lasts one cycle", {31'd0, got_after}, 32'd0);

        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            retire_pulse = 1'b1;
            @(negedge clk);
            retire_pulse = 1'b0;
        end

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].addr, VECS[i].funct, VECS[i].rs1z, VECS[i].rdz, VECS[i].priv);
            check(got_valid == 1'b1, $sformatf("R1 vec %0d valid", i),
                  {31'd0, got_valid}, 32'd1);
            check(got_ill == VECS[i].ill, $sformatf("R%0d vec %0d illegal", VECS[i].rq, i),
                  {31'd0, got_ill}, {31'd0, VECS[i].ill});
            check(got_data == VECS[i].data, $sformatf("R%0d vec %0d data", VECS[i].rq, i),
                  got_data, VECS[i].data);
        end

        // R9: ISA register unchanged by the writes above
        access(12'h301, 3'd2, 1'b1, 1'b0, 2'd3);
        check(got_data == 32'h4014_1100, "R9 isa after writes", got_data, 32'h4014_1100);
        // R6: rejected writes left the counter alone
        access(12'hC02, 3'd2, 1'b1, 1'b0, 2'd3);
        check(got_data == 32'd5, "R6 count after rejected writes", got_data, 32'd5);

        // R7: time_in moves right after acceptance; the sampled value is returned
        @(negedge clk);
        time_in      = 64'h0000_0007_0000_1111;
        req_valid    = 1'b1;
        req_addr     = 12'hC01;
        req_funct    = 3'd2;
        req_rs1_zero = 1'b1;
        req_rd_zero  = 1'b0;
        cur_priv     = 2'd3;
        @(posedge clk);
        @(negedge clk);
        time_in  = 64'h0000_0009_0000_2222;
        // R1: request held with a new address while busy must be ignored
        req_addr = 12'hF14;
        @(posedge clk);
        @(negedge clk);
        got_valid = rsp_valid;
        got_data  = rsp_rdata;
        req_valid = 1'b0;
        check(got_valid && got_data == 32'h0000_1111, "R7 time sampled at accept",
              got_data, 32'h0000_1111);
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 busy request ignored (no reply)",
              {31'd0, rsp_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 busy request ignored (still idle)",
              {31'd0, rsp_valid}, 32'd0);

        // R7: high half of a fresh sample
        access(12'hC81, 3'd2, 1'b1, 1'b0, 2'd0);
        check(got_data == 32'h0000_0009, "R7 time high half", got_data, 32'h0000_0009);
        // R8: hart id unaffected by the input changing after reset
        access(12'hF14, 3'd6, 1'b1, 1'b0, 2'd3);
        check(got_data == 32'h0000_00A5, "R8 hart id after reset", got_data, 32'h0000_00A5);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule